// File: doc/BRIEF.md
# Instruction Run Control with Breakpoint Halt

This block governs whether a 16-bit minicomputer core executes instructions. A front panel sends it one-cycle command pulses to run, single-step, stop or master-clear. A separate console stop key acts like the stop command. The block holds one of four execution states. While the core executes, it times every instruction from the instruction's class and its count of indirection and indexing levels. On the last cycle of each instruction it raises a completion strobe.

Each completion strobe is an instruction boundary. At that point the block decides whether execution goes on. Execution halts when any of these is true:
- a single step has just finished;
- a stop request is pending;
- the breakpoint register equals the next program address that the core presents.

The breakpoint comparison is not made for the first instruction after a run command. This lets a run restart from the very address it halted on. An opcode that the core flags as undefined sends the block into a sticky error halt, and only master clear leaves it.

The core supplies the class, depth, undefined-opcode flag and next address. It holds them valid during the first cycle of each instruction, which the block marks with a strobe. The next address must also be valid on the final cycle.

Top module: `cpu_run_ctrl`

## Requirements
- R1: After reset, state_code is 00, halted is 1, exec_en is 0, ins_done is 0 and bp_value is 0.
- R2: state_code encodes 00 halted, 01 running, 10 stepping, 11 error. halted is 1 exactly in the halted and error states, and exec_en is 1 exactly in the running and stepping states.
- R3: An instruction lasts 4 cycles for ins_class 00 (generic) and 01 (direct memory reference), 5 cycles for class 10 and 6 cycles for class 11, when ins_depth is 0. ins_done is high only on its last cycle.
- R4: Each unit of ins_depth (levels of indirection or indexing) adds exactly one cycle to the instruction.
- R5: cmd_step in the halted state executes exactly one instruction. The state is 00 on the cycle after its ins_done.
- R6: After cmd_run, instructions follow back to back with no idle cycle until a halt condition occurs.
- R7: While running, if bp_value equals next_pc on an ins_done cycle, the state is 00 on the next cycle.
- R8: The breakpoint comparison is skipped for the first instruction completed after cmd_run.
- R9: ins_illegal high on an ins_first cycle gives state 11 on the next cycle, and that instruction produces no ins_done.
- R10: In the error state, cmd_run, cmd_step, cmd_stop and stop_key have no effect. Only cmd_mclr leaves it.
- R11: cmd_stop or stop_key during execution lets the current instruction finish to its full length and then halts.
- R12: cmd_mclr from any state gives state 00 and bp_value 0 on the next cycle.
- R13: bp_wr_en loads bp_wr_data into the breakpoint register, and the value is visible on bp_value on the next cycle.
- R14: cmd_run or cmd_step while running does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_run | input | 1 | Panel run pulse |
| cmd_step | input | 1 | Panel single-step pulse |
| cmd_stop | input | 1 | Panel stop pulse |
| stop_key | input | 1 | Console stop key |
| cmd_mclr | input | 1 | Master clear pulse |
| bp_wr_en | input | 1 | Breakpoint register write enable |
| bp_wr_data | input | ADDR_W | Breakpoint value to write |
| ins_class | input | 2 | Instruction timing class, valid on ins_first |
| ins_depth | input | DEPTH_W | Indirection/indexing levels, valid on ins_first |
| ins_illegal | input | 1 | Undefined opcode flag, valid on ins_first |
| next_pc | input | ADDR_W | Address of next instruction, valid on ins_done |
| exec_en | output | 1 | Core may advance this cycle |
| ins_first | output | 1 | First cycle of an instruction |
| ins_done | output | 1 | Last cycle of an instruction |
| halted | output | 1 | Not executing (halted or error) |
| state_code | output | 2 | Execution state code |
| bp_value | output | ADDR_W | Breakpoint register contents |

## Verification
A miscounted cycle counter shows up within one instruction: ins_done moves off its expected cycle, and the next ins_first moves with it. The bench counts these cycles for every class and depth. A lost skip flag or a wrong breakpoint compare shows on the cycle right after the first or second completion, as a state code that halts too early or never halts. A leaky error state or a bad master clear changes state_code and bp_value one cycle after the command that exposes it.

// File: rtl/rc_pkg.sv
package rc_pkg;

  typedef enum logic [1:0] {
    ST_HALT = 2'b00,
    ST_RUN  = 2'b01,
    ST_STEP = 2'b10,
    ST_ERR  = 2'b11
  } rc_state_e;

  typedef enum logic [1:0] {
    IC_GEN   = 2'b00,
    IC_MREF  = 2'b01,
    IC_CPLX5 = 2'b10,
    IC_CPLX6 = 2'b11
  } ins_class_e;

  localparam int unsigned BASE_MAX = 6;

  // base cycle count of a class with no indirection
  function automatic logic [2:0] base_cycles(input logic [1:0] cls);
    logic [2:0] r;
    case (ins_class_e'(cls))
      IC_CPLX5: r = 3'd5;
      IC_CPLX6: r = 3'd6;
      default:  r = 3'd4;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rc_cycle_timer.sv
module rc_cycle_timer #(
  parameter int unsigned DEPTH_W = 2,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               abort,
  input  logic [1:0]         cls,
  input  logic [DEPTH_W-1:0] depth,
  output logic               first,
  output logic               last
);
  import rc_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d, len_cur;
  logic             cnt_en;

  assign first   = active && (cnt_q == '0);
  assign len_cur = first ? (CNT_W'(base_cycles(cls)) + CNT_W'(depth)) : len_q;
  assign last    = active && (cnt_q == len_cur - CNT_W'(1));

  assign cnt_en = active || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    len_d = len_q;
    if (first) len_d = len_cur;
    if (!active || abort || last) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

endmodule

// File: rtl/rc_bp_unit.sv
module rc_bp_unit #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] bp_q,
  output logic              match
);
  logic [ADDR_W-1:0] bp_d;
  logic              bp_en;

  assign bp_en = mclr || wr_en;

  always_comb begin
    bp_d = wr_data;
    if (mclr) bp_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bp_q <= '0;
    else if (bp_en) bp_q <= bp_d;
  end

  assign match = (bp_q == next_pc);

endmodule

// File: rtl/rc_fsm.sv
module rc_fsm (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_run,
  input  logic             cmd_step,
  input  logic             stop_any,
  input  logic             mclr,
  input  logic             ins_first,
  input  logic             ins_illegal,
  input  logic             ins_last,
  input  logic             bp_match,
  output rc_pkg::rc_state_e state
);
  import rc_pkg::*;

  rc_state_e st_q, st_d;
  logic      skip_q, skip_d;
  logic      stop_q, stop_d;
  logic      bp_halt;

  assign bp_halt = (st_q == ST_RUN) && !skip_q && bp_match;

  always_comb begin
    st_d   = st_q;
    skip_d = skip_q;
    stop_d = stop_q;
    case (st_q)
      ST_HALT: begin
        stop_d = 1'b0;
        if (cmd_run) begin
          st_d   = ST_RUN;
          skip_d = 1'b1;
        end else if (cmd_step) begin
          st_d = ST_STEP;
        end
      end
      ST_RUN, ST_STEP: begin
        if (stop_any) stop_d = 1'b1;
        if (ins_first && ins_illegal) begin
          st_d = ST_ERR;
        end else if (ins_last) begin
          skip_d = 1'b0;
          if ((st_q == ST_STEP) || stop_any || stop_q || bp_halt) begin
            st_d   = ST_HALT;
            stop_d = 1'b0;
          end
        end
      end
      default: st_d = ST_ERR;
    endcase
    if (mclr) begin
      st_d   = ST_HALT;
      skip_d = 1'b0;
      stop_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HALT;
      skip_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      skip_q <= skip_d;
      stop_q <= stop_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/cpu_run_ctrl.sv
module cpu_run_ctrl #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DEPTH_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_run,
  input  logic               cmd_step,
  input  logic               cmd_stop,
  input  logic               stop_key,
  input  logic               cmd_mclr,
  input  logic               bp_wr_en,
  input  logic [ADDR_W-1:0]  bp_wr_data,
  input  logic [1:0]         ins_class,
  input  logic [DEPTH_W-1:0] ins_depth,
  input  logic               ins_illegal,
  input  logic [ADDR_W-1:0]  next_pc,
  output logic               exec_en,
  output logic               ins_first,
  output logic               ins_done,
  output logic               halted,
  output logic [1:0]         state_code,
  output logic [ADDR_W-1:0]  bp_value
);
  import rc_pkg::*;

  localparam int unsigned MAX_LEN = BASE_MAX + (2**DEPTH_W) - 1;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  rc_state_e state;
  logic      t_first, t_last, bp_match, abort;

  assign exec_en = (state == ST_RUN) || (state == ST_STEP);
  assign abort   = cmd_mclr || (t_first && ins_illegal);

  rc_cycle_timer #(.DEPTH_W(DEPTH_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(exec_en), .abort(abort),
    .cls(ins_class), .depth(ins_depth), .first(t_first), .last(t_last)
  );

  rc_bp_unit #(.ADDR_W(ADDR_W)) u_bp (
    .clk(clk), .rst_n(rst_n), .mclr(cmd_mclr), .wr_en(bp_wr_en),
    .wr_data(bp_wr_data), .next_pc(next_pc), .bp_q(bp_value), .match(bp_match)
  );

  rc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_run(cmd_run), .cmd_step(cmd_step),
    .stop_any(cmd_stop || stop_key), .mclr(cmd_mclr), .ins_first(t_first),
    .ins_illegal(ins_illegal), .ins_last(t_last), .bp_match(bp_match), .state(state)
  );

  assign ins_first  = t_first;
  assign ins_done   = t_last && !(t_first && ins_illegal);
  assign halted     = !exec_en;
  assign state_code = state;

endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DEPTH_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_mclr,
  input logic               cmd_run,
  input logic               cmd_step,
  input logic [1:0]         ins_class,
  input logic [DEPTH_W-1:0] ins_depth,
  input logic               ins_illegal,
  input logic               ins_first,
  input logic               ins_done,
  input logic               halted,
  input logic [1:0]         state_code,
  input logic [ADDR_W-1:0]  bp_value
);
  int unsigned seen_q;
  int unsigned want_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 0;
      want_q <= 0;
    end else if (ins_first) begin
      seen_q <= 1;
      want_q <= 4 + ((ins_class == 2'b10) ? 1 : 0) + ((ins_class == 2'b11) ? 2 : 0)
                + int'(ins_depth);
    end else if (!halted) begin
      seen_q <= seen_q + 1;
    end
  end

  // R4 also covered: depth is part of want_q
  p_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_done && !ins_first) |-> (seen_q + 1 == want_q));

  p_state_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halted == ((state_code == 2'b00) || (state_code == 2'b11)));

  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_done && state_code == 2'b10 && !cmd_mclr) |=> (state_code == 2'b00));

  p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_first && ins_illegal && !cmd_mclr) |=> (state_code == 2'b11));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'b11 && !cmd_mclr) |=> (state_code == 2'b11));

  p_mclr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mclr |=> (state_code == 2'b00 && bp_value == '0));

  p_run_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'b01 && !ins_done && !ins_first && !cmd_mclr && (cmd_run || cmd_step))
      |=> (state_code == 2'b01));

endmodule

bind cpu_run_ctrl rc_checker #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_mclr(cmd_mclr), .cmd_run(cmd_run), .cmd_step(cmd_step),
  .ins_class(ins_class), .ins_depth(ins_depth), .ins_illegal(ins_illegal),
  .ins_first(ins_first), .ins_done(ins_done), .halted(halted),
  .state_code(state_code), .bp_value(bp_value)
);

// File: tb/cpu_run_ctrl_tb.sv
module cpu_run_ctrl_tb;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 2;
  localparam logic [AW-1:0] BPA = 16'h0123;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_run = 0, cmd_step = 0, cmd_stop = 0, stop_key = 0, cmd_mclr = 0;
  logic bp_wr_en = 0;
  logic [AW-1:0] bp_wr_data = '0;
  logic [1:0] ins_class = '0;
  logic [DW-1:0] ins_depth = '0;
  logic ins_illegal = 0;
  logic [AW-1:0] next_pc = '0;
  logic exec_en, ins_first, ins_done, halted;
  logic [1:0] state_code;
  logic [AW-1:0] bp_value;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cpu_run_ctrl #(.ADDR_W(AW), .DEPTH_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_run(cmd_run), .cmd_step(cmd_step), .cmd_stop(cmd_stop),
    .stop_key(stop_key), .cmd_mclr(cmd_mclr), .bp_wr_en(bp_wr_en), .bp_wr_data(bp_wr_data),
    .ins_class(ins_class), .ins_depth(ins_depth), .ins_illegal(ins_illegal), .next_pc(next_pc),
    .exec_en(exec_en), .ins_first(ins_first), .ins_done(ins_done), .halted(halted),
    .state_code(state_code), .bp_value(bp_value)
  );

  // {run_mode, class, depth, illegal, expected length}
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 2'b00, 2'd0, 1'b0, 4'd4},
    {1'b0, 2'b01, 2'd0, 1'b0, 4'd4},
    {1'b0, 2'b10, 2'd0, 1'b0, 4'd5},
    {1'b0, 2'b11, 2'd0, 1'b0, 4'd6},
    {1'b0, 2'b00, 2'd3, 1'b0, 4'd7},
    {1'b0, 2'b11, 2'd3, 1'b0, 4'd9},
    {1'b1, 2'b00, 2'd1, 1'b0, 4'd5},
    {1'b1, 2'b10, 2'd2, 1'b0, 4'd7},
    {1'b1, 2'b11, 2'd0, 1'b0, 4'd6},
    {1'b1, 2'b01, 2'd3, 1'b0, 4'd7},
    {1'b0, 2'b00, 2'd0, 1'b1, 4'd0},
    {1'b1, 2'b10, 2'd1, 1'b1, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  // count cycles up to and including ins_done, starting on an instruction's first cycle
  task automatic count_ins(output int n);
    n = 1;
    while (!ins_done && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic write_bp(input logic [AW-1:0] v);
    bp_wr_data = v;
    pulse(bp_wr_en);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(state_code == 2'b00 && halted && !exec_en && !ins_done, "R1 reset state",
        int'(state_code), 0);
    chk(bp_value == '0, "R1 bp reset", int'(bp_value), 0);

    // R13
    write_bp(16'hBEEF);
    chk(bp_value == 16'hBEEF, "R13 bp write", int'(bp_value), 'hBEEF);

    // table walk: R3 R4 R5 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      pulse(cmd_mclr);
      write_bp(BPA);
      ins_class   = VEC[i][8:7];
      ins_depth   = VEC[i][6:5];
      ins_illegal = VEC[i][4];
      next_pc     = BPA;
      if (VEC[i][9]) pulse(cmd_run); else pulse(cmd_step);
      chk(state_code == (VEC[i][9] ? 2'b01 : 2'b10) && exec_en, "R2 exec code",
          int'(state_code), VEC[i][9] ? 1 : 2);
      if (VEC[i][4]) begin
        chk(!ins_done, "R9 no done on illegal", int'(ins_done), 0);
        @(negedge clk);
        chk(state_code == 2'b11 && halted, "R9 error state", int'(state_code), 3);
        ins_illegal = 1'b0;
      end else begin
        count_ins(n);
        chk(n == int'(VEC[i][3:0]), "R3 R4 length", n, int'(VEC[i][3:0]));
        @(negedge clk);
        if (!VEC[i][9]) begin
          chk(state_code == 2'b00, "R5 step halts", int'(state_code), 0);
        end else begin
          chk(state_code == 2'b01 && ins_first, "R8 first bp skipped", int'(state_code), 1);
          count_ins(n);
          chk(n == int'(VEC[i][3:0]), "R6 second length", n, int'(VEC[i][3:0]));
          @(negedge clk);
          chk(state_code == 2'b00, "R7 bp halt", int'(state_code), 0);
        end
      end
    end

    // R10: error ignores run/step/stop, left only by mclr
    pulse(cmd_run);
    pulse(cmd_step);
    pulse(cmd_stop);
    pulse(stop_key);
    chk(state_code == 2'b11, "R10 error sticky", int'(state_code), 3);
    pulse(cmd_mclr);
    chk(state_code == 2'b00 && bp_value == '0, "R12 mclr from error", int'(state_code), 0);

    // R6 R14: free run without breakpoint, commands ignored
    write_bp(16'hFFFF);
    next_pc = 16'h0010;
    ins_class = 2'b00; ins_depth = '0;
    pulse(cmd_run);
    for (int k = 0; k < 3; k++) begin
      count_ins(n);
      chk(n == 4, "R6 back to back", n, 4);
      @(negedge clk);
      chk(ins_first && state_code == 2'b01, "R6 continues", int'(state_code), 1);
    end
    pulse(cmd_run);
    pulse(cmd_step);
    chk(state_code == 2'b01, "R14 run/step ignored", int'(state_code), 1);

    // R12 mclr while running
    pulse(cmd_mclr);
    chk(state_code == 2'b00 && !exec_en && bp_value == '0, "R12 mclr while running",
        int'(state_code), 0);

    // R11 stop command mid instruction
    write_bp(16'hFFFF);
    ins_class = 2'b11;
    pulse(cmd_run);
    @(negedge clk);
    pulse(cmd_stop);
    n = 3;
    while (!ins_done && n < 20) begin @(negedge clk); n++; end
    chk(n == 6, "R11 stop finishes instruction", n, 6);
    @(negedge clk);
    chk(state_code == 2'b00, "R11 stop halts", int'(state_code), 0);

    // R11 console stop key
    ins_class = 2'b00;
    pulse(cmd_run);
    pulse(stop_key);
    n = 2;
    while (!ins_done && n < 20) begin @(negedge clk); n++; end
    chk(n == 4, "R11 key finishes instruction", n, 4);
    @(negedge clk);
    chk(state_code == 2'b00 && halted, "R11 key halts", int'(state_code), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule